// File: doc/BRIEF.md
# Interleaved Replicated Lookup Table

This block answers one table lookup per clock cycle, without a single fast memory, by keeping several identical copies of the table. A rotating pointer sends consecutive lookup samples to the copies in turn, so each copy only has to serve one read every N cycles. An output selector collects the results in the same rotation and presents them in the order the samples arrived, a fixed two cycles after each sample.

The table is changed through a slow update port. Each update is written into every copy in the same cycle, so all copies stay identical. Each copy has its own write port next to its read port, so updates never hold up the lookup stream and the update port has no backpressure. Table contents are undefined after reset until they are written.

Top module: `ilut_top`

## Requirements
- R1: While reset is active and during the cycles that follow it, `res_valid` is 0 and `res_data` is 0.
- R2: A lookup presented with `lk_valid`=1 in cycle t produces `res_valid`=1 in cycle t+2, with `res_data` equal to the entry stored at `lk_addr`. A cycle with `lk_valid`=0 produces `res_valid`=0 two cycles later.
- R3: The k-th valid lookup since reset is served by copy (k mod N). The copy pointer starts at 0, advances by one for each valid lookup, wraps after N-1, and does not move on bubble cycles. At most one copy is read in any cycle.
- R4: An update (`upd_en`=1, `upd_addr`, `upd_data`) in cycle t is stored in every copy. Every lookup of that address presented from cycle t+1 onward returns `upd_data`, whichever copy serves it.
- R5: Updates never stall lookups. A lookup stream that is valid in every cycle keeps producing a valid result in every cycle while updates arrive.
- R6: A lookup presented in the same cycle as an update to the same address returns either the old entry or the new one.
- R7: While `res_valid` is 0, `res_data` keeps its previous value.
- R8: Back-to-back valid lookups of any length give back-to-back valid results, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the lookup and update paths |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_valid | input | 1 | A lookup sample is present this cycle |
| lk_addr | input | AW (10) | Table index of the lookup |
| upd_en | input | 1 | Write strobe for a table update |
| upd_addr | input | AW (10) | Table index to update |
| upd_data | input | DW (16) | New entry value |
| res_valid | output | 1 | A lookup result is present this cycle |
| res_data | output | DW (16) | Lookup result |

## Verification
The bench writes the whole table, then runs long random streams with bubbles mixed in. A design whose pointer advanced on bubbles, or failed to wrap, would hand a sample to a copy other than the one the selector reads, and so return another sample's value. Four lookups of the same address in a row, right after an update, reach every copy. A design that wrote only one copy would return the stale value on three of them. Dense write traffic under a fully valid stream, and reads that hit the address being written in the same cycle, show whether updates steal read slots (a missing result) or corrupt the read (a value that is neither old nor new). Bubbles between results show whether `res_data` drifts while `res_valid` is low.

// File: rtl/ilut_pkg.sv
package ilut_pkg;
  localparam int DEF_AW = 10;
  localparam int DEF_DW = 16;
  localparam int DEF_NB = 4;

  // pointer width for a given copy count
  function automatic int ptr_width(input int nb);
    return (nb > 1) ? $clog2(nb) : 1;
  endfunction

  // next copy index with wrap
  function automatic int next_copy(input int cur, input int nb);
    return (cur >= nb - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/ilut_rst_sync.sv
module ilut_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ilut_steer.sv
module ilut_steer #(
  parameter int AW = ilut_pkg::DEF_AW,
  parameter int NB = ilut_pkg::DEF_NB,
  localparam int PW = ilut_pkg::ptr_width(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  output logic [NB-1:0] rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] ptr_q,
  output logic          s1_valid,
  output logic [PW-1:0] s1_sel
);
  logic [PW-1:0] ptr_d;
  logic          ptr_ce;

  // pointer next state: advance only on valid samples
  always_comb begin
    ptr_ce = in_valid;
    ptr_d  = ptr_q;
    if (ptr_ce) begin
      if (ptr_q == PW'(NB - 1)) ptr_d = '0;
      else                      ptr_d = ptr_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_ce) ptr_q <= ptr_d;
  end

  // one-hot read enable per copy
  for (genvar g = 0; g < NB; g++) begin : g_dec
    assign rd_en[g] = in_valid && (ptr_q == PW'(g));
  end

  assign rd_addr = in_addr;

  // tag stage tracking which copy holds the pending result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sel   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_sel <= ptr_q;
    end
  end
endmodule

// File: rtl/ilut_bank.sv
module ilut_bank #(
  parameter int AW = ilut_pkg::DEF_AW,
  parameter int DW = ilut_pkg::DEF_DW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);
  logic [DW-1:0] mem [DEPTH];

  // write side
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read side, separate port
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/ilut_gather.sv
module ilut_gather #(
  parameter int DW = ilut_pkg::DEF_DW,
  parameter int NB = ilut_pkg::DEF_NB,
  localparam int PW = ilut_pkg::ptr_width(NB)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s1_valid,
  input  logic [PW-1:0]          s1_sel,
  input  logic [NB-1:0][DW-1:0]  bank_q,
  output logic                   out_valid,
  output logic [DW-1:0]          out_data
);
  logic [DW-1:0] pick;
  logic          data_ce;

  always_comb begin
    pick    = '0;
    data_ce = s1_valid;
    for (int i = 0; i < NB; i++) begin
      if (s1_sel == PW'(i)) pick = bank_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (data_ce) out_data <= pick;
    end
  end
endmodule

// File: rtl/ilut_top.sv
module ilut_top #(
  parameter int AW = ilut_pkg::DEF_AW,
  parameter int DW = ilut_pkg::DEF_DW,
  parameter int NB = ilut_pkg::DEF_NB,
  localparam int PW = ilut_pkg::ptr_width(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_addr,
  input  logic [DW-1:0] upd_data,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);
  logic                  rst_sync_n;
  logic [NB-1:0]         rd_en;
  logic [AW-1:0]         rd_addr;
  logic [PW-1:0]         ptr_q;
  logic                  s1_valid;
  logic [PW-1:0]         s1_sel;
  logic [NB-1:0][DW-1:0] bank_q;

  ilut_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ilut_steer #(.AW(AW), .NB(NB)) u_steer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (lk_valid),
    .in_addr  (lk_addr),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .ptr_q    (ptr_q),
    .s1_valid (s1_valid),
    .s1_sel   (s1_sel)
  );

  // every copy receives the same write
  for (genvar b = 0; b < NB; b++) begin : g_copy
    ilut_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk     (clk),
      .wr_en   (upd_en),
      .wr_addr (upd_addr),
      .wr_data (upd_data),
      .rd_en   (rd_en[b]),
      .rd_addr (rd_addr),
      .rd_q    (bank_q[b])
    );
  end

  ilut_gather #(.DW(DW), .NB(NB)) u_gather (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .s1_valid  (s1_valid),
    .s1_sel    (s1_sel),
    .bank_q    (bank_q),
    .out_valid (res_valid),
    .out_data  (res_data)
  );
endmodule

// File: rtl/ilut_top_chk.sv
module ilut_top_chk #(
  parameter int DW = ilut_pkg::DEF_DW,
  parameter int NB = ilut_pkg::DEF_NB,
  localparam int PW = ilut_pkg::ptr_width(NB)
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          lk_valid,
  input logic          res_valid,
  input logic [DW-1:0] res_data,
  input logic [PW-1:0] ptr_q,
  input logic [NB-1:0] rd_en
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)      age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age >= 2'd2) |-> (res_valid == $past(lk_valid, 2)));

  // R3
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age >= 2'd1 && $past(lk_valid)) |->
      (int'(ptr_q) == ilut_pkg::next_copy(int'($past(ptr_q)), NB)));

  // R3
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age >= 2'd1 && !$past(lk_valid)) |-> $stable(ptr_q));

  // R3
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(rd_en) && ($countones(rd_en) == int'(lk_valid)));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age >= 2'd1 && !res_valid) |-> $stable(res_data));

  // R1
  reset_out_chk: assert property (@(posedge clk)
    (!rst_sync_n) |-> (!res_valid && res_data == '0));
endmodule

bind ilut_top ilut_top_chk #(.DW(DW), .NB(NB)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .lk_valid   (lk_valid),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .ptr_q      (ptr_q),
  .rd_en      (rd_en)
);

// File: tb/ilut_top_test.sv
module ilut_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          lk_valid;
  logic [AW-1:0] lk_addr;
  logic          upd_en;
  logic [AW-1:0] upd_addr;
  logic [DW-1:0] upd_data;
  logic          res_valid;
  logic [DW-1:0] res_data;

  int checks;
  int failures;
  bit done;

  logic [DW-1:0] model [DEPTH];
  // expectation pipeline, index 1 is the oldest
  logic          ev   [2];
  logic [DW-1:0] eold [2];
  logic [DW-1:0] enew [2];
  string         etag [2];
  logic [DW-1:0] last_data;

  ilut_top uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .upd_en    (upd_en),
    .upd_addr  (upd_addr),
    .upd_data  (upd_data),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic bit data_ok(input logic [DW-1:0] got, input logic [DW-1:0] a,
                                 input logic [DW-1:0] b);
    return (got === a) || (got === b);
  endfunction

  task automatic check_outputs();
    checks++;
    if (res_valid !== ev[1]) begin
      failures++;
      $display("FAIL %s valid: actual=%0b expected=%0b", etag[1], res_valid, ev[1]);
    end else if (ev[1]) begin
      checks++;
      if (!data_ok(res_data, eold[1], enew[1])) begin
        failures++;
        $display("FAIL %s data: actual=%h expected=%h or %h", etag[1], res_data,
                 eold[1], enew[1]);
      end
    end else begin
      checks++;
      // R7: held during a bubble
      if (res_data !== last_data) begin
        failures++;
        $display("FAIL R7 hold: actual=%h expected=%h", res_data, last_data);
      end
    end
    last_data = res_data;
  endtask

  // one cycle: check the result of two cycles ago, then drive this cycle
  task automatic cycle(input bit lv, input logic [AW-1:0] la, input bit we,
                       input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                       input string tag);
    logic [DW-1:0] old_v;
    logic [DW-1:0] new_v;
    @(negedge clk);
    check_outputs();
    old_v = model[la];
    new_v = (we && wa == la) ? wd : old_v;  // R6: either is accepted
    ev[1] = ev[0];   eold[1] = eold[0]; enew[1] = enew[0]; etag[1] = etag[0];
    ev[0] = lv;      eold[0] = old_v;   enew[0] = new_v;   etag[0] = tag;
    if (we) model[wa] = wd;
    lk_valid = lv; lk_addr = la;
    upd_en = we; upd_addr = wa; upd_data = wd;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] hot;
    checks = 0; failures = 0; done = 1'b0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; lk_valid = 1'b0; lk_addr = '0;
    upd_en = 1'b0; upd_addr = '0; upd_data = '0;
    for (int i = 0; i < 2; i++) begin
      ev[i] = 1'b0; eold[i] = '0; enew[i] = '0; etag[i] = "R2";
    end
    last_data = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    checks++;
    if (res_valid !== 1'b0 || res_data !== '0) begin
      failures++;
      $display("FAIL R1: actual=%b/%h expected=0/0", res_valid, res_data);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: still idle after release
    checks++;
    if (res_valid !== 1'b0 || res_data !== '0) begin
      failures++;
      $display("FAIL R1 release: actual=%b/%h expected=0/0", res_valid, res_data);
    end

    // fill the table; idle lookups must give bubbles (R2)
    for (int a = 0; a < DEPTH; a++)
      cycle(1'b0, '0, 1'b1, AW'(a), DW'($urandom()), "R2");

    // R8: long back-to-back stream covering every copy
    for (int i = 0; i < 40; i++)
      cycle(1'b1, AW'($urandom()), 1'b0, '0, '0, "R8");

    // R4: update, then same address on four consecutive samples
    hot = AW'(37);
    cycle(1'b0, '0, 1'b1, hot, 16'hBEEF, "R4");
    for (int i = 0; i < 4; i++) cycle(1'b1, hot, 1'b0, '0, '0, "R4");
    cycle(1'b0, '0, 1'b1, hot, 16'h1234, "R4");
    for (int i = 0; i < 5; i++) cycle(1'b1, hot, 1'b0, '0, '0, "R4");

    // R6: read and write of the same address in one cycle
    for (int i = 0; i < 8; i++) begin
      hot = AW'($urandom());
      cycle(1'b1, hot, 1'b1, hot, DW'($urandom()), "R6");
      cycle(1'b1, hot, 1'b0, '0, '0, "R4");
    end

    // R5: fully valid stream with an update every cycle
    for (int i = 0; i < 300; i++)
      cycle(1'b1, AW'($urandom()), 1'b1, AW'($urandom()), DW'($urandom()), "R5");

    // R3: bubbles in random places must not shift the rotation
    for (int i = 0; i < 3000; i++) begin
      bit lv;
      bit we;
      lv = ($urandom() % 4) != 0;
      we = ($urandom() % 50) == 0;
      cycle(lv, AW'($urandom()), we, AW'($urandom()), DW'($urandom()), "R3");
    end

    // R3: single samples separated by bubble runs of various lengths
    for (int i = 0; i < 12; i++) begin
      cycle(1'b1, AW'($urandom()), 1'b0, '0, '0, "R3");
      for (int j = 0; j < (i % 5); j++) cycle(1'b0, '0, 1'b0, '0, '0, "R3");
    end

    // drain
    cycle(1'b0, '0, 1'b0, '0, '0, "R2");
    cycle(1'b0, '0, 1'b0, '0, '0, "R2");
    cycle(1'b0, '0, 1'b0, '0, '0, "R2");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule